// File: doc/BRIEF.md
# Microinstruction Sequencer with Test Branching and Return Stack

This block holds the microinstruction counter of a microprogrammed controller and picks the control-store address for the next cycle. The control store (outside this block) presents the microword found at the current address. The sequencer receives the fields of that word: an operation code, a one-hot test-select mask, an alternate field, and a relative-mode bit. It also receives the test indicator vector from the execution unit and a computed address from the datapath. From these it forms the next address.

There are four operation codes. A test operation looks at a single selected indicator. When the indicator is 0 the counter falls through to counter+1. When it is 1 the counter jumps to a target. That target is either the alternate field used as an absolute address, or the counter plus the alternate field. A call pushes the return address onto a small push-down stack and jumps to the target. A return pops the most recent return address into the counter. A computed jump loads the datapath address.

When main memory is busy, a hold input freezes the counter and the stack, so the current microword is issued again. Stack overflow and underflow set a sticky error flag.

A two-state machine tracks the hold: ST_RUN (advancing) and ST_HOLD (the last cycle was held). The transitions are:
- ST_RUN→ST_HOLD when hold is high.
- ST_HOLD→ST_HOLD while hold stays high.
- ST_HOLD→ST_RUN when hold drops.
- ST_RUN→ST_RUN otherwise.
- Reset enters ST_RUN.

Top module: `usq_sequencer`

## Requirements
- R1: A synchronous active-high reset sets the address to 0, empties the return stack, clears the error flag and enters ST_RUN.
- R2: With op = 0 (test) and an all-zero test mask, the next address is the current address + 1, whatever the indicators are.
- R3: With op = 0 and a mask that has exactly one bit set, the next address is the target when the indicator at that bit is 1. It is the current address + 1 when that indicator is 0.
- R4: With op = 0 and a mask that has two or more bits set, no test is made and the next address is the current address + 1.
- R5: The target is the alternate field when the relative bit is 0. It is (current address + alternate field) modulo 2^AW when the relative bit is 1.
- R6: With op = 1 (call) and the stack not full, the current address + 1 is pushed and the next address is the target.
- R7: With op = 2 (return) and the stack not empty, the most recently pushed value is popped into the counter. Nesting is last-in first-out up to DEPTH levels.
- R8: A call while the stack holds DEPTH entries sets the error flag, leaves the stack unchanged and falls through to the current address + 1.
- R9: A return while the stack is empty sets the error flag, leaves the stack unchanged and falls through to the current address + 1.
- R10: Once set, the error flag stays high until reset.
- R11: With op = 3 (computed jump), the next address is the datapath address input.
- R12: While hold is high, the address, the stack and the error flag do not change. The stall output equals hold, and the replay output is high in the cycle after each held cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hold_req | input | 1 | Main memory busy; freezes sequencing |
| op | input | 2 | 0 test, 1 call, 2 return, 3 computed jump |
| test_sel | input | NT | One-hot test-select mask |
| test_ind | input | NT | Test indicators from the execution unit |
| alt_field | input | AW | Alternate address or increment |
| rel_mode | input | 1 | 1: alternate field is an increment |
| dp_addr | input | AW | Computed address from the datapath |
| ua_o | output | AW | Current control-store address |
| stall_o | output | 1 | Sequencing is held this cycle |
| replay_o | output | 1 | Previous cycle was held; word is reissued |
| err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
A hold and a stack operation can fall in the same cycle. The hold must win: a held call must not push, and a held return must not pop or raise the error flag. Random stimulus raises hold on about one cycle in five across every operation code. Directed steps also hold a call at full depth and a return on an empty stack. The result is judged by later unheld returns, whose addresses must follow the bench's own stack model, and by the error flag, which must stay low across the held faults.

// File: rtl/usq_pkg.sv
package usq_pkg;
    typedef enum logic [1:0] {
        OP_TEST = 2'd0,
        OP_CALL = 2'd1,
        OP_RET  = 2'd2,
        OP_JUMP = 2'd3
    } usq_op_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } usq_state_e;
endpackage

// File: rtl/usq_test_eval.sv
module usq_test_eval #(
    parameter int NT = 8
) (
    input  logic [NT-1:0] test_sel,
    input  logic [NT-1:0] test_ind,
    output logic          taken
);
    logic [NT-1:0] hit;
    logic          single;

    // A mask counts as one test only when exactly one bit is set.
    always_comb begin
        single = (test_sel != '0) && ((test_sel & (test_sel - 1'b1)) == '0);
        hit    = test_sel & test_ind;
        taken  = single && (hit != '0);
    end
endmodule

// File: rtl/usq_ret_stack.sv
module usq_ret_stack #(
    parameter int AW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] top,
    output logic          full,
    output logic          empty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CW-1:0] cnt_q;
    logic [AW-1:0] ent_q [DEPTH];

    always_comb begin
        full  = (cnt_q == CW'(DEPTH));
        empty = (cnt_q == '0);
        top   = ent_q[IW'(cnt_q - 1'b1)];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Each slot has its own write enable, decoded from the fill level.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g] <= '0;
            end else if (push && cnt_q == CW'(g)) begin
                ent_q[g] <= din;
            end
        end
    end
endmodule

// File: rtl/usq_next_addr.sv
module usq_next_addr
    import usq_pkg::*;
#(
    parameter int AW = 8
) (
    input  usq_op_e       op,
    input  logic [AW-1:0] ua,
    input  logic [AW-1:0] alt_field,
    input  logic          rel_mode,
    input  logic [AW-1:0] dp_addr,
    input  logic [AW-1:0] stk_top,
    input  logic          taken,
    input  logic          stk_full,
    input  logic          stk_empty,
    output logic [AW-1:0] nxt,
    output logic [AW-1:0] ret_addr,
    output logic          push,
    output logic          pop,
    output logic          fault
);
    logic [AW-1:0] seq_addr;
    logic [AW-1:0] tgt_addr;

    always_comb begin
        seq_addr = ua + 1'b1;
        tgt_addr = rel_mode ? (ua + alt_field) : alt_field;
        ret_addr = seq_addr;
        nxt      = seq_addr;
        push     = 1'b0;
        pop      = 1'b0;
        fault    = 1'b0;
        unique case (op)
            OP_TEST: nxt = taken ? tgt_addr : seq_addr;
            OP_CALL: begin
                if (stk_full) begin
                    fault = 1'b1;
                end else begin
                    push = 1'b1;
                    nxt  = tgt_addr;
                end
            end
            OP_RET: begin
                if (stk_empty) begin
                    fault = 1'b1;
                end else begin
                    pop = 1'b1;
                    nxt = stk_top;
                end
            end
            OP_JUMP: nxt = dp_addr;
            default: nxt = seq_addr;
        endcase
    end
endmodule

// File: rtl/usq_sequencer.sv
module usq_sequencer
    import usq_pkg::*;
#(
    parameter int AW    = 8,
    parameter int NT    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold_req,
    input  logic [1:0]    op,
    input  logic [NT-1:0] test_sel,
    input  logic [NT-1:0] test_ind,
    input  logic [AW-1:0] alt_field,
    input  logic          rel_mode,
    input  logic [AW-1:0] dp_addr,
    output logic [AW-1:0] ua_o,
    output logic          stall_o,
    output logic          replay_o,
    output logic          err_o
);
    usq_state_e    state_q, state_d;
    logic [AW-1:0] ua_q;
    logic          err_q;
    logic          advance;
    logic          taken;
    logic [AW-1:0] nxt, ret_addr, stk_top;
    logic          push, pop, fault, stk_full, stk_empty;

    assign advance = !hold_req;

    usq_test_eval #(.NT(NT)) i_test (
        .test_sel (test_sel),
        .test_ind (test_ind),
        .taken    (taken)
    );

    usq_next_addr #(.AW(AW)) i_next (
        .op        (usq_op_e'(op)),
        .ua        (ua_q),
        .alt_field (alt_field),
        .rel_mode  (rel_mode),
        .dp_addr   (dp_addr),
        .stk_top   (stk_top),
        .taken     (taken),
        .stk_full  (stk_full),
        .stk_empty (stk_empty),
        .nxt       (nxt),
        .ret_addr  (ret_addr),
        .push      (push),
        .pop       (pop),
        .fault     (fault)
    );

    usq_ret_stack #(.AW(AW), .DEPTH(DEPTH)) i_stack (
        .clk   (clk),
        .rst   (rst),
        .push  (push && advance),
        .pop   (pop && advance),
        .din   (ret_addr),
        .top   (stk_top),
        .full  (stk_full),
        .empty (stk_empty)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  state_d = hold_req ? ST_HOLD : ST_RUN;
            ST_HOLD: state_d = hold_req ? ST_HOLD : ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // Microinstruction counter and sticky fault flag
    always_ff @(posedge clk) begin
        if (rst) begin
            ua_q  <= '0;
            err_q <= 1'b0;
        end else if (advance) begin
            ua_q <= nxt;
            if (fault) begin
                err_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        ua_o     = ua_q;
        err_o    = err_q;
        stall_o  = hold_req;
        replay_o = (state_q == ST_HOLD);
    end
endmodule

// File: rtl/usq_sequencer_chk.sv
module usq_sequencer_chk #(
    parameter int AW    = 8,
    parameter int NT    = 8,
    parameter int DEPTH = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          hold_req,
    input logic [1:0]    op,
    input logic [NT-1:0] test_sel,
    input logic [NT-1:0] test_ind,
    input logic [AW-1:0] alt_field,
    input logic          rel_mode,
    input logic [AW-1:0] dp_addr,
    input logic [AW-1:0] ua_o,
    input logic          stall_o,
    input logic          replay_o,
    input logic          err_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (ua_o == '0 && !err_o && !replay_o));

    // R2
    fall_through_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_req && op == 2'd0 && test_sel == '0) |=> ua_o == AW'($past(ua_o) + 1'b1));

    // R3
    abs_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_req && op == 2'd0 && $onehot(test_sel) && (test_sel & test_ind) != '0 && !rel_mode)
        |=> ua_o == $past(alt_field));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    // R11
    jump_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_req && op == 2'd3) |=> ua_o == $past(dp_addr));

    // R12
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        hold_req |=> ($stable(ua_o) && replay_o && $stable(err_o)));
endmodule

bind usq_sequencer usq_sequencer_chk #(.AW(AW), .NT(NT), .DEPTH(DEPTH)) i_usq_chk (
    .clk       (clk),
    .rst       (rst),
    .hold_req  (hold_req),
    .op        (op),
    .test_sel  (test_sel),
    .test_ind  (test_ind),
    .alt_field (alt_field),
    .rel_mode  (rel_mode),
    .dp_addr   (dp_addr),
    .ua_o      (ua_o),
    .stall_o   (stall_o),
    .replay_o  (replay_o),
    .err_o     (err_o)
);

// File: tb/test_usq_sequencer.sv
module test_usq_sequencer;
    localparam int AW    = 8;
    localparam int NT    = 8;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hold_req = 1'b0;
    logic [1:0]    op = 2'd0;
    logic [NT-1:0] test_sel = '0;
    logic [NT-1:0] test_ind = '0;
    logic [AW-1:0] alt_field = '0;
    logic          rel_mode = 1'b0;
    logic [AW-1:0] dp_addr = '0;
    logic [AW-1:0] ua_o;
    logic          stall_o, replay_o, err_o;

    int nchk = 0;
    int nfail = 0;

    // bench model
    logic [AW-1:0] m_ua;
    logic [AW-1:0] m_stk [DEPTH];
    int            m_dep;
    logic          m_err;

    always #4 clk = ~clk;

    usq_sequencer #(.AW(AW), .NT(NT), .DEPTH(DEPTH)) i_usq_sequencer (
        .clk(clk), .rst(rst), .hold_req(hold_req), .op(op),
        .test_sel(test_sel), .test_ind(test_ind), .alt_field(alt_field),
        .rel_mode(rel_mode), .dp_addr(dp_addr), .ua_o(ua_o),
        .stall_o(stall_o), .replay_o(replay_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ones(input logic [NT-1:0] v);
        int n = 0;
        for (int i = 0; i < NT; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; hold_req = 1'b0; op = 2'd0; test_sel = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_ua = '0; m_dep = 0; m_err = 1'b0;
        chk(ua_o == '0, "R1", "ua after reset", int'(ua_o), 0);
        chk(err_o == 1'b0, "R1", "err after reset", int'(err_o), 0);
        chk(replay_o == 1'b0, "R1", "replay after reset", int'(replay_o), 0);
    endtask

    // Called at a negedge: drive one microword, predict, check at next negedge.
    task automatic step(input logic [1:0] o, input logic [NT-1:0] s,
                        input logic [NT-1:0] ind, input logic [AW-1:0] a,
                        input logic r, input logic [AW-1:0] d, input logic h);
        logic [AW-1:0] seqv, tgt, nxt;
        string lab;
        op = o; test_sel = s; test_ind = ind; alt_field = a;
        rel_mode = r; dp_addr = d; hold_req = h;
        seqv = m_ua + 1'b1;
        tgt  = r ? AW'(m_ua + a) : a;
        nxt  = seqv;
        if (h) begin
            lab = "R12";
            nxt = m_ua;
        end else begin
            case (o)
                2'd0: begin
                    if (s == '0) lab = "R2";
                    else if (ones(s) > 1) lab = "R4";
                    else begin
                        lab = r ? "R5" : "R3";
                        if ((s & ind) != '0) nxt = tgt;
                    end
                end
                2'd1: begin
                    if (m_dep == DEPTH) begin
                        lab = "R8"; m_err = 1'b1;
                    end else begin
                        lab = "R6"; m_stk[m_dep] = seqv; m_dep++; nxt = tgt;
                    end
                end
                2'd2: begin
                    if (m_dep == 0) begin
                        lab = "R9"; m_err = 1'b1;
                    end else begin
                        lab = "R7"; m_dep--; nxt = m_stk[m_dep];
                    end
                end
                default: begin
                    lab = "R11"; nxt = d;
                end
            endcase
        end
        #1;
        chk(stall_o == h, "R12", "stall", int'(stall_o), int'(h));
        @(negedge clk);
        m_ua = nxt;
        chk(ua_o == nxt, lab, "ua", int'(ua_o), int'(nxt));
        chk(err_o == m_err, "R10", "err", int'(err_o), int'(m_err));
        chk(replay_o == h, "R12", "replay", int'(replay_o), int'(h));
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        #(8 * 150000);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        // directed cases
        step(2'd0, 8'h04, 8'h04, 8'h40, 1'b0, 8'h00, 1'b0); // R3 taken -> 0x40
        step(2'd0, 8'h04, 8'hFB, 8'h10, 1'b0, 8'h00, 1'b0); // R3 not taken -> 0x41
        step(2'd0, 8'h00, 8'hFF, 8'h10, 1'b0, 8'h00, 1'b0); // R2 -> 0x42
        step(2'd0, 8'h06, 8'hFF, 8'h10, 1'b0, 8'h00, 1'b0); // R4 -> 0x43
        step(2'd0, 8'h01, 8'h01, 8'hF0, 1'b1, 8'h00, 1'b0); // R5 wrap -> 0x33
        step(2'd3, 8'h00, 8'h00, 8'h00, 1'b0, 8'h80, 1'b0); // R11 -> 0x80
        step(2'd3, 8'h00, 8'h00, 8'h00, 1'b0, 8'h10, 1'b1); // R12 held
        step(2'd3, 8'h00, 8'h00, 8'h00, 1'b0, 8'h10, 1'b1); // R12 held
        step(2'd1, 8'h00, 8'h00, 8'h20, 1'b0, 8'h00, 1'b0); // R6
        step(2'd1, 8'h00, 8'h00, 8'h04, 1'b1, 8'h00, 1'b0); // R6 relative
        step(2'd1, 8'h00, 8'h00, 8'h60, 1'b0, 8'h00, 1'b1); // held call, no push
        step(2'd1, 8'h00, 8'h00, 8'h60, 1'b0, 8'h00, 1'b0);
        step(2'd1, 8'h00, 8'h00, 8'h70, 1'b0, 8'h00, 1'b0); // full
        step(2'd1, 8'h00, 8'h00, 8'h90, 1'b0, 8'h00, 1'b1); // held overflow, no err
        step(2'd1, 8'h00, 8'h00, 8'h90, 1'b0, 8'h00, 1'b0); // R8 overflow
        for (int i = 0; i < DEPTH; i++)
            step(2'd2, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0); // R7 LIFO
        step(2'd2, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0);     // R9 underflow
        step(2'd0, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0);     // R10 still set
        do_reset();
        step(2'd2, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 1'b1);     // held underflow
        step(2'd2, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0);     // R9
        // constrained random
        for (int it = 0; it < 1600; it++) begin
            logic [1:0]    o;
            logic [NT-1:0] s;
            int            k;
            if (it % 200 == 0) do_reset();
            o = 2'($urandom % 4);
            if (o == 2'd1 && m_dep == DEPTH && ($urandom % 4) != 0) o = 2'd2;
            if (o == 2'd2 && m_dep == 0 && ($urandom % 4) != 0) o = 2'd1;
            k = int'($urandom % 3);
            if (k == 0) s = '0;
            else if (k == 1) s = NT'(1) << ($urandom % NT);
            else s = NT'($urandom);
            step(o, s, NT'($urandom), AW'($urandom), 1'($urandom),
                 AW'($urandom), ($urandom % 5) == 0);
        end
        summary();
        $finish;
    end
endmodule